// File: doc/BRIEF.md
# Compressed Key-Obfuscated Scan Wrapper

This block wraps several equal-length scan chains whose shift paths contain secret, key-controlled inversions. A small group of scan-in pins feeds the chains through a fanout expander: every chain in a group receives the same pin bit in each shift cycle. On the way out, an XOR compactor folds the last cell of every chain in a group onto one scan-out pin. Capture is parallel. With shift disabled, every cell loads its functional response in the same cycle.

A key register is written through a load strobe. A chain position with a key gate XORs the travelling scan bit with its key bit on the way into that cell. Captured data bypasses the gates. An inversion therefore changes both the stimulus that reaches each downstream cell and the response that passes through the gate on its way out. The effect of a key bit stays inside the chain that holds its gate. Key bits at positions without a gate do nothing. The cells loaded in the same shift cycle form one slice. The number of slices equals the chain length.

Top module: `obf_scan_cmp`

## Requirements
- R1: An active-low asynchronous reset clears every chain cell and the key register. After reset every scan-out pin reads 0, and shifting with no key loaded passes data without inversion.
- R2: Chain j takes its serial input from scan-in pin floor(j/RATIO). All chains of a group see the same bit in each shift cycle.
- R3: While scan_en_i is 1, cell i (i>0) of each chain loads cell i-1 of that chain. If a gate sits at position i, the value is XORed with the key bit at that position.
- R4: While scan_en_i is 1, cell 0 of chain j loads its scan-in bit. If position 0 of the chain is gated, the bit is XORed with that key bit.
- R5: While scan_en_i is 0, cell i of chain j loads cap_data_i[j*CHAIN_LEN+i] in one cycle, independent of the key.
- R6: scan_out_o[p] equals the XOR of the last cells (index CHAIN_LEN-1) of chains p*RATIO to p*RATIO+RATIO-1. It is combinational from those cells.
- R7: The key register takes key_i at a clock edge where key_load_i is 1 and holds otherwise. A shift in that same edge still uses the old key.
- R8: A key bit at a position whose GATE_MASK bit is 0 has no effect on any output.
- R9: A key bit only changes data in the chain that holds its gate. Scan-out pins of other groups are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | 1: shift all chains, 0: parallel capture |
| scan_in_i | input | NUM_CHAINS/RATIO | Compressed scan-in pins |
| cap_data_i | input | NUM_CHAINS*CHAIN_LEN | Capture data, bit j*CHAIN_LEN+i for cell i of chain j |
| key_load_i | input | 1 | Key register write strobe |
| key_i | input | NUM_CHAINS*CHAIN_LEN | Key value, bit j*CHAIN_LEN+i for position i of chain j |
| scan_out_o | output | NUM_CHAINS/RATIO | Compacted scan-out pins |

## Verification
The hard part is telling apart one chain's inversions from its group partner's. The compactor XORs chains together, so a flipped key bit can look exactly like a flipped capture bit in the neighbouring chain. The stimulus sets up that case with directed loads: a key with only one gated bit set, a key with only ungated bits set, and capture patterns that are equal across a group. Every compacted output after each of these loads is compared with a bench model of expansion, per-chain inversion, capture and compaction. Randomized runs mix shifts, captures and key loads in the same cycles.

// File: rtl/obf_scan_pkg.sv
package obf_scan_pkg;
  function automatic int unsigned group_of(input int unsigned chain, input int unsigned ratio);
    return chain / ratio;
  endfunction
endpackage

// File: rtl/scan_fanout.sv
module scan_fanout #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned RATIO      = 2,
  localparam int unsigned NPINS     = NUM_CHAINS / RATIO
) (
  input  logic [NPINS-1:0]      pin_i,
  output logic [NUM_CHAINS-1:0] chain_si_o
);
  import obf_scan_pkg::*;

  for (genvar j = 0; j < NUM_CHAINS; j++) begin : g_fan
    assign chain_si_o[j] = pin_i[group_of(j, RATIO)];
  end

  // every chain in a group must carry its leader's bit
  always_comb begin
    for (int j = 1; j < NUM_CHAINS; j++) begin
      if ((j % RATIO) != 0)
        p_group_same_r2: assert (chain_si_o[j] == chain_si_o[j-1]);
    end
  end
endmodule

// File: rtl/obf_chain.sv
module obf_chain #(
  parameter int unsigned          CHAIN_LEN = 3,
  parameter logic [CHAIN_LEN-1:0] GATES     = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 si_i,
  input  logic [CHAIN_LEN-1:0] cap_i,
  input  logic [CHAIN_LEN-1:0] key_i,
  output logic                 so_o
);
  logic [CHAIN_LEN-1:0] cell_q, shift_d;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic src;
    if (i == 0) begin : g_head
      assign src = si_i;
    end else begin : g_body
      assign src = cell_q[i-1];
    end
    if (GATES[i]) begin : g_gate
      assign shift_d[i] = src ^ key_i[i];
    end else begin : g_wire
      assign shift_d[i] = src;
      if (i > 0) begin : g_chk
        p_ungated_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
          shift_i |=> cell_q[i] == $past(cell_q[i-1]));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cell_q <= '0;
    else if (shift_i) cell_q <= shift_d;
    else              cell_q <= cap_i;
  end

  assign so_o = cell_q[CHAIN_LEN-1];

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> so_o == $past(cap_i[CHAIN_LEN-1]));
endmodule

// File: rtl/xor_compactor.sv
module xor_compactor #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned RATIO      = 2,
  localparam int unsigned NPINS     = NUM_CHAINS / RATIO
) (
  input  logic [NUM_CHAINS-1:0] chain_so_i,
  output logic [NPINS-1:0]      pin_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_comb begin
      pin_o[p] = 1'b0;
      for (int r = 0; r < RATIO; r++) pin_o[p] ^= chain_so_i[p*RATIO + r];
    end
    always_comb begin
      p_parity_r6: assert (pin_o[p] == ($countones(chain_so_i[p*RATIO +: RATIO]) % 2 == 1));
    end
  end
endmodule

// File: rtl/obf_scan_cmp.sv
module obf_scan_cmp #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CHAIN_LEN  = 3,
  parameter int unsigned RATIO      = 2,
  parameter logic [NUM_CHAINS*CHAIN_LEN-1:0] GATE_MASK = 12'h88A,
  localparam int unsigned NPINS     = NUM_CHAINS / RATIO,
  localparam int unsigned NBITS     = NUM_CHAINS * CHAIN_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_en_i,
  input  logic [NPINS-1:0] scan_in_i,
  input  logic [NBITS-1:0] cap_data_i,
  input  logic             key_load_i,
  input  logic [NBITS-1:0] key_i,
  output logic [NPINS-1:0] scan_out_o
);
  logic [NBITS-1:0]      key_q;
  logic [NUM_CHAINS-1:0] chain_si, chain_so;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         key_q <= '0;
    else if (key_load_i) key_q <= key_i;
  end

  p_key_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_load_i |=> $stable(key_q));

  scan_fanout #(.NUM_CHAINS(NUM_CHAINS), .RATIO(RATIO)) u_fanout (
    .pin_i      (scan_in_i),
    .chain_si_o (chain_si)
  );

  for (genvar j = 0; j < NUM_CHAINS; j++) begin : g_chain
    obf_chain #(
      .CHAIN_LEN (CHAIN_LEN),
      .GATES     (GATE_MASK[j*CHAIN_LEN +: CHAIN_LEN])
    ) u_chain (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (scan_en_i),
      .si_i    (chain_si[j]),
      .cap_i   (cap_data_i[j*CHAIN_LEN +: CHAIN_LEN]),
      .key_i   (key_q[j*CHAIN_LEN +: CHAIN_LEN]),
      .so_o    (chain_so[j])
    );
  end

  xor_compactor #(.NUM_CHAINS(NUM_CHAINS), .RATIO(RATIO)) u_compact (
    .chain_so_i (chain_so),
    .pin_o      (scan_out_o)
  );
endmodule

// File: tb/obf_scan_cmp_tb_top.sv
module obf_scan_cmp_tb_top;
  localparam int unsigned NC = 4, L = 3, R = 2;
  localparam int unsigned NP = NC / R, NW = NC * L;
  localparam logic [NW-1:0] GM = 12'h88A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic se = 1'b0, kl = 1'b0;
  logic [NP-1:0] si = '0;
  logic [NW-1:0] cap = '0, kv = '0;
  logic [NP-1:0] so;
  logic [NW-1:0] m_cells = '0, m_key = '0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  obf_scan_cmp #(.NUM_CHAINS(NC), .CHAIN_LEN(L), .RATIO(R), .GATE_MASK(GM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(se), .scan_in_i(si), .cap_data_i(cap),
    .key_load_i(kl), .key_i(kv), .scan_out_o(so));

  function automatic logic [NP-1:0] compact(input logic [NW-1:0] c);
    logic [NP-1:0] o = '0;
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < R; r++) o[p] ^= c[(p*R + r)*L + L - 1];
    return o;
  endfunction

  function automatic logic [NW-1:0] next_cells(input logic [NW-1:0] c, input logic s,
      input logic [NP-1:0] pins, input logic [NW-1:0] cd, input logic [NW-1:0] k);
    logic [NW-1:0] n;
    if (!s) return cd;
    for (int j = 0; j < NC; j++)
      for (int i = 0; i < L; i++) begin
        logic b = (i == 0) ? pins[j / R] : c[j*L + i - 1];
        n[j*L + i] = b ^ (GM[j*L + i] & k[j*L + i]);
      end
    return n;
  endfunction

  task automatic check(input string tag);
    logic [NP-1:0] exp = compact(m_cells);
    checks++;
    if (so !== exp) begin
      errors++;
      $display("FAIL %s: scan_out=%b expected=%b", tag, so, exp);
    end
  endtask

  task automatic step(input logic s, input logic [NP-1:0] pins, input logic [NW-1:0] cd,
                      input logic l, input logic [NW-1:0] k, input string tag);
    se = s; si = pins; cap = cd; kl = l; kv = k;
    @(posedge clk);
    m_cells = next_cells(m_cells, s, pins, cd, m_key);
    if (l) m_key = k;
    #2;
    check(tag);
  endtask

  task automatic flush(input string tag);
    for (int c = 0; c < L; c++) step(1'b1, '0, '0, 1'b0, '0, tag);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5C4A));
    #19;
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: no key loaded, pattern passes uninverted
    for (int c = 0; c < 6; c++) step(1'b1, NP'($urandom), '0, 1'b0, '0, "R1 R2 R4");
    // R5: capture with a key present, then unload
    step(1'b1, '0, '0, 1'b1, '1, "R7 load");
    for (int c = 0; c < 4; c++) begin
      step(1'b0, '0, NW'($urandom), 1'b0, '0, "R5 capture");
      flush("R5 R3 R6 unload");
    end
    // R6: equal capture in group partners cancels on the pin
    step(1'b0, '0, 12'b111_111_101_101, 1'b0, '0, "R6 equal pair");
    flush("R6 R3");
    // R4: only chain 1 head gate set
    step(1'b1, '0, '0, 1'b1, 12'h008, "R4 R7 key");
    step(1'b0, '0, '0, 1'b0, '0, "R5 clear");
    flush("R4 R9 head inversion");
    // R8: only ungated key bits set
    step(1'b1, '0, '0, 1'b1, ~GM, "R8 R7 key");
    step(1'b0, '0, 12'hA5C, 1'b0, '0, "R8 capture");
    for (int c = 0; c < 5; c++) step(1'b1, NP'($urandom), '0, 1'b0, '0, "R8 ungated");
    // R9: gate in chain 0 only; group 1 pin untouched
    step(1'b1, '0, '0, 1'b1, 12'h002, "R9 R7 key");
    step(1'b0, '0, '0, 1'b0, '0, "R9 clear");
    flush("R9 own chain");
    // R7: key_i changes with load low, shift in load cycle uses old key
    step(1'b1, '0, '0, 1'b0, '1, "R7 hold");
    flush("R7 hold");
    step(1'b1, 2'b11, '0, 1'b1, '1, "R7 old key in load edge");
    flush("R7 R3 new key");
    // random mix
    for (int c = 0; c < 300; c++)
      step(($urandom % 4) != 0, NP'($urandom), NW'($urandom), ($urandom % 8) == 0,
           NW'($urandom), "R2 R3 R4 R5 R6 R7 random");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule